// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for a four-beat burst. A load pulse captures a full external address; from the following cycle the block presents that address and, on each cycle its active-low advance input is low, steps the two low address bits to the next beat of the burst. The upper address bits are carried unchanged from the load for as long as the burst lasts.

Two beat orders are offered. In linear order the low bits count up by one modulo four from the starting offset. In interleaved order the low bits are the starting offset XOR a beat count that runs 0, 1, 2, 3. The order input is captured together with the address when a load occurs, so a whole burst follows one order. After four advances the low bits are back at the starting offset. A load can arrive in any cycle, including back to back, and always wins over a simultaneous advance.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, addr_out is all zeros and the captured order is linear.
- R2: When load is 1 at a rising clock edge, addr_out equals the addr_in sampled at that edge from just after that edge on, with a beat count of zero.
- R3: With linear order captured (order_sel was 0 at load), each edge with adv_n = 0 and load = 0 makes the low two bits of addr_out increase by one modulo four (start 10 gives 10, 11, 00, 01).
- R4: With interleaved order captured (order_sel was 1 at load), the low two bits of addr_out equal the starting offset XOR the number of advances modulo four (start 01 gives 01, 00, 11, 10; start 11 gives 11, 10, 01, 00).
- R5: After four advances in either order, the low two bits of addr_out return to the starting offset, and a fifth advance repeats the second beat.
- R6: An edge with adv_n = 1 and load = 0 leaves addr_out unchanged.
- R7: When load = 1 and adv_n = 0 at the same edge, the load takes effect and no step is applied.
- R8: Bits above the low two of addr_out never change except at a load, including when the low bits wrap from 11 to 00.
- R9: A change of order_sel without a load has no effect on the sequence of the burst in progress.
- R10: Loads on consecutive edges each take effect, so a new address is presented every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Capture addr_in and order_sel, restart the beat count |
| adv_n | input | 1 | Step to the next beat, active low |
| order_sel | input | 1 | Beat order for the next load: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W (18) | External start address |
| addr_out | output | ADDR_W (18) | Current burst address |

## Verification
The bound checker watches every cycle that a load lands the sampled address on the output, that an idle cycle holds the output, that the upper bits move only on a load, and that a linear-order advance adds one modulo four to the low bits. The interleaved XOR pattern, the return to the starting offset after four beats, indifference to order_sel mid-burst and the load-over-advance priority in a running burst are shown by the bench's scenarios, whose scoreboard computes each expected address from an independent model of the start offset and beat count.

// File: rtl/burst_pkg.sv
// Package: shared widths and the beat-order encoding for the burst sequencer.
package burst_pkg;
    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

    // Map a start offset and a beat count to the offset of that beat.
    function automatic logic [1:0] beat_offset(input order_e ord,
                                               input logic [1:0] start,
                                               input logic [1:0] count);
        if (ord == ORDER_XOR)
            return start ^ count;
        else
            return start + count;
    endfunction
endpackage

// File: rtl/burst_start_reg.sv
// Start register: holds the loaded address and the beat order of the burst.
// Assumes load is a synchronous pulse; holds its contents otherwise.
module burst_start_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] start_addr,
    output order_e            order_q
);
    // Capture address and order on every load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr <= '0;
            order_q    <= ORDER_LINEAR;
        end else if (load) begin
            start_addr <= addr_in;
            order_q    <= order_e'(order_sel);
        end
    end
endmodule

// File: rtl/burst_beat_ctr.sv
// Beat counter: counts advances since the last load, wrapping modulo 2**CNT_W.
// Assumes load has priority over advance in the same cycle.
module burst_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv_n,
    output logic [CNT_W-1:0] count
);
    // Restart on load, step on an active advance, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= '0;
        else if (!adv_n)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Top: burst address sequencer. Combines the captured start address with the
// beat count, mapped through the captured order, to form the current address.
// Assumes ADDR_W > 2; only the low two bits ever step.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int OFS_W = 2;
    localparam int HI_W  = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] start_addr;
    order_e            order_q;
    logic [OFS_W-1:0]  beat_cnt;
    logic [OFS_W-1:0]  beat_ofs;

    burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .order_sel  (order_sel),
        .addr_in    (addr_in),
        .start_addr (start_addr),
        .order_q    (order_q)
    );

    burst_beat_ctr #(.CNT_W(OFS_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv_n (adv_n),
        .count (beat_cnt)
    );

    // Offset of the current beat in the captured order.
    always_comb beat_ofs = beat_offset(order_q, start_addr[OFS_W-1:0], beat_cnt);

    // Upper bits straight from the start register, low bits from the map.
    always_comb addr_out = {start_addr[ADDR_W-1 -: HI_W], beat_ofs};
endmodule

// File: rtl/burst_addr_gen_chk.sv
// Checker for burst_addr_gen, bound to every instance. Keeps its own copy of
// the order seen at the last load, taken from the port.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic              adv_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);
    logic mode_seen;

    // Track the order requested at the most recent load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_seen <= 1'b0;
        else if (load)
            mode_seen <= order_sel;
    end

    // R2 and R7: a load lands the sampled address, advance or not.
    a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr_out == $past(addr_in));

    // R6: idle edge holds the address.
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n) |=> $stable(addr_out));

    // R8: upper bits move only on a load.
    a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));

    // R3: linear step adds one modulo four.
    a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n && !mode_seen) |=>
            addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .adv_n     (adv_n),
    .order_sel (order_sel),
    .addr_in   (addr_in),
    .addr_out  (addr_out)
);

// File: tb/burst_addr_gen_tb.sv
// Scoreboard bench: a driver task applies one cycle of stimulus and queues the
// expected address; a monitor compares after each edge.
module burst_addr_gen_tb;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    logic [AW-1:0] m_base = '0;
    logic          m_mode = 1'b0;
    logic [1:0]    m_cnt  = '0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .adv_n(adv_n),
        .order_sel(order_sel), .addr_in(addr_in), .addr_out(addr_out)
    );

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] lo;
        lo = m_mode ? (m_base[1:0] ^ m_cnt) : 2'(m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    // Drive one cycle at the falling edge and queue the result expected after it.
    task automatic step(input logic ld, input logic an, input logic md,
                        input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        load = ld; adv_n = an; order_sel = md; addr_in = a;
        if (ld) begin
            m_base = a; m_mode = md; m_cnt = 2'd0;
        end else if (!an) begin
            m_cnt = m_cnt + 2'd1;
        end
        exp_q.push_back(model_addr());
        tag_q.push_back(tag);
    endtask

    // Monitor: compare shortly after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            logic [AW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (addr_out !== e) begin
                n_bad++;
                $display("FAIL %s: addr_out=%h expected=%h", t, addr_out, e);
            end
        end
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state
        #1; n_chk++;
        if (addr_out !== '0) begin
            n_bad++;
            $display("FAIL R1: addr_out=%h expected=%h", addr_out, {AW{1'b0}});
        end
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, '0, "R1");  // step from reset: linear 0 -> 1

        // R2/R3: linear from offset 10
        step(1'b1, 1'b1, 1'b0, 18'h12346, "R2");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, '0, "R3");
        // R5: wrap back to start, then second beat again
        step(1'b0, 1'b0, 1'b0, '0, "R5");
        step(1'b0, 1'b0, 1'b0, '0, "R5");
        // R6: hold
        step(1'b0, 1'b1, 1'b0, 18'h3FFFF, "R6");
        step(1'b0, 1'b1, 1'b1, 18'h00000, "R6");

        // R4: interleaved from 01 and from 11
        step(1'b1, 1'b1, 1'b1, 18'h0A5A1, "R4");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, '0, "R4");
        step(1'b1, 1'b0, 1'b1, 18'h00F03, "R7");   // load with advance
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, '0, "R4");
        step(1'b0, 1'b0, 1'b1, '0, "R5");

        // R8: upper bits all ones, linear wrap 11 -> 00 must not carry
        step(1'b1, 1'b1, 1'b0, 18'h3FFFF, "R8");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, '0, "R8");

        // R9: order_sel flips mid-burst without load
        step(1'b1, 1'b1, 1'b1, 18'h10002, "R9");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, '0, "R9");
        step(1'b1, 1'b1, 1'b0, 18'h20001, "R9");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, '0, "R9");

        // R7: load mid-burst beats a simultaneous advance
        step(1'b1, 1'b0, 1'b0, 18'h05552, "R7");
        step(1'b0, 1'b0, 1'b0, '0, "R3");

        // R10: loads on consecutive edges
        for (int i = 0; i < 6; i++)
            step(1'b1, i[0], i[1], 18'(32'h1111 * (i + 1)), "R10");
        step(1'b0, 1'b0, 1'b0, '0, "R10");

        @(negedge clk); load = 1'b0; adv_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule